// File: doc/BRIEF.md
# Reloadable Alarm Timer

This block is a register-mapped 16-bit up-counter that raises an alarm interrupt when a programmed interval has elapsed. Software selects a count source and a power-of-two divider. It then programs a top value and a start value. The counter climbs from the start value to the top value. On the following count it drops back to the start value, and at that moment it sets a sticky wrap flag. The interrupt line is high while that flag and its enable are both set. For an alarm of N counts, software writes N−1 as the top value and leaves the start value at 0.

The register bus is a plain single-cycle strobe interface. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address. A build parameter swaps the byte order of write and read data for big-endian hosts. The external fixed-frequency tick is brought into the bus clock domain through a synchronizer. Each of its rising edges then counts as one source tick.

Top module: `reload_alarm_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: Register offsets: control/status 0x00, counter 0x04, top value 0x08, start value 0x4C. Control layout: bits [2:0] divider exponent, bits [4:3] source select, bit 6 interrupt enable, bit 7 wrap flag. Other control bits read 0, and unmapped offsets read 0.
- R3: Source code 1 gives one source tick per bus clock cycle. Codes 0 and 3 stop the counter, which holds its value.
- R4: Source code 2 gives one source tick per rising edge of `tick_in`.
- R5: Counting happens once every 2^e source ticks, where e is the divider exponent (0 to 7). The divider restarts from zero while the source code is 0, so after the source is enabled the k-th count falls on source tick k·2^e.
- R6: On a count, a counter equal to the top value reloads with the start value. Otherwise it increments.
- R7: The wrap flag is set on the same edge as the top-to-start reload.
- R8: Writing 0 to control bit 7 clears the flag. Writing 1 leaves it unchanged. If a reload coincides with a clearing write, the flag ends up set.
- R9: Any write to the counter offset loads the start value, whatever the data. This write takes precedence over a count in the same cycle.
- R10: The counter, top value and start value keep only the low 16 bits of written data and read back zero-extended.
- R11: `irq` is high exactly when the wrap flag and the interrupt enable are both set.
- R12: With `BIG_ENDIAN`=1, write data and read data are byte-reversed at the bus. For example, bus data 0x48000000 written to control is taken as 0x00000048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_in | input | 1 | Asynchronous fixed-frequency tick |
| irq | output | 1 | Alarm interrupt request |

## Verification
The main sweep covers every combination of divider exponents 0 to 3, three start/top pairs and five elapsed-cycle counts, all on the bus-clock source. One pair has an equal start and top value, which pins the counter to a single value. The sweep checks the counter against start + (floor(K/2^e) mod period) and the flag against whether a full period has passed. Together these separate an off-by-one in the reload point, a divider that does not restart, and a flag raised one count early or late. A second sweep sends a fixed number of `tick_in` edges under each exponent, which shows whether edges are counted once each. Directed cycles then land a clearing write on the exact reload edge, write ones to the flag, and reload the counter in the middle of a run. A second instance built big-endian can raise its interrupt only if the swapped control write is decoded correctly.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W = 32;

    // byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_COUNT = 8'h04;
    localparam logic [7:0] OFS_TOP   = 8'h08;
    localparam logic [7:0] OFS_START = 8'h4C;

    // control field positions
    localparam int EXP_LSB  = 0;
    localparam int EXP_W    = 3;
    localparam int SRC_LSB  = 3;
    localparam int SRC_W    = 2;
    localparam int IE_BIT   = 6;
    localparam int FLAG_BIT = 7;

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF   = 2'd0,
        SRC_BUS   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_RSVD  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic             flag;
        logic             irq_en;
        src_sel_e         src;
        logic [EXP_W-1:0] div_exp;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < DATA_W / 8; b++) begin
            r[b*8 +: 8] = d[(DATA_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EXP_LSB +: EXP_W] = c.div_exp;
        w[SRC_LSB +: SRC_W] = c.src;
        w[IE_BIT]           = c.irq_en;
        w[FLAG_BIT]         = c.flag;
        return w;
    endfunction

endpackage

// File: rtl/timer_tick_sync.sv
module timer_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= 1'b0;
                end else if (s == 0) begin
                    chain[s] <= tick_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign tick_pulse = chain[STAGES-1] & ~last;

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
    import timer_pkg::*;
#(
    parameter int XW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  src_sel_e      src,
    input  logic [XW-1:0] div_exp,
    input  logic          fixed_pulse,
    output logic          count_en
);
    localparam int DIV_W = (1 << XW) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;
    logic             src_tick;

    always_comb begin
        unique case (src)
            SRC_BUS:   src_tick = 1'b1;
            SRC_FIXED: src_tick = fixed_pulse;
            default:   src_tick = 1'b0;
        endcase
    end

    generate
        for (genvar i = 0; i < DIV_W; i++) begin : g_mask
            assign mask[i] = (i < int'(div_exp));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || src == SRC_OFF) begin
            div_cnt <= '0;
        end else if (src_tick) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign count_en = src_tick && ((div_cnt & mask) == mask);

    assert_en_needs_src_R3: assert property (@(posedge clk) disable iff (rst)
        count_en |-> (src == SRC_BUS || src == SRC_FIXED));

    assert_div_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_OFF) |=> (div_cnt == '0));

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          count_en,
    input  logic          load,
    input  logic [CW-1:0] top_val,
    input  logic [CW-1:0] start_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = count_en && !load && (cnt == top_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start_val;
        end else if (count_en) begin
            if (cnt == top_val) cnt <= start_val;
            else                cnt <= cnt + 1'b1;
        end
    end

    assert_reload_at_top_R6: assert property (@(posedge clk) disable iff (rst)
        (count_en && !load && cnt == top_val) |=> (cnt == $past(start_val)));

    assert_write_loads_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(start_val)));

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (count_en && !load && cnt != top_val) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/reload_alarm_timer.sv
module reload_alarm_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit BIG_ENDIAN  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tick_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] rd;
    logic [7:0]        ofs;
    logic              wr_ctrl, wr_count, wr_top, wr_start;
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  top_q, start_q, cnt;
    logic              fixed_pulse, count_en, wrap;
    logic              clear_req;

    generate
        if (BIG_ENDIAN) begin : g_be
            assign wd        = swap_bytes(bus_wdata);
            assign bus_rdata = swap_bytes(rd);
        end else begin : g_le
            assign wd        = bus_wdata;
            assign bus_rdata = rd;
        end
        if (ADDR_W > 8) begin : g_wide
            wire unused_addr_hi = &{1'b0, bus_addr[ADDR_W-1:8]};
            assign ofs = bus_addr[7:0];
        end else begin : g_narrow
            assign ofs = 8'(bus_addr);
        end
    endgenerate

    wire unused_wd_hi = &{1'b0, wd[DATA_W-1:CNT_W]};

    assign wr_ctrl  = bus_we && (ofs == OFS_CTRL);
    assign wr_count = bus_we && (ofs == OFS_COUNT);
    assign wr_top   = bus_we && (ofs == OFS_TOP);
    assign wr_start = bus_we && (ofs == OFS_START);
    assign clear_req = wr_ctrl && !wd[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            top_q   <= '0;
            start_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.div_exp <= wd[EXP_LSB +: EXP_W];
                ctrl.src     <= src_sel_e'(wd[SRC_LSB +: SRC_W]);
                ctrl.irq_en  <= wd[IE_BIT];
            end
            if (wrap)           ctrl.flag <= 1'b1;
            else if (clear_req) ctrl.flag <= 1'b0;
            if (wr_top)   top_q   <= wd[CNT_W-1:0];
            if (wr_start) start_q <= wd[CNT_W-1:0];
        end
    end

    timer_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick_async (tick_in),
        .tick_pulse (fixed_pulse)
    );

    timer_prescaler #(.XW(EXP_W)) u_presc (
        .clk         (clk),
        .rst         (rst),
        .src         (ctrl.src),
        .div_exp     (ctrl.div_exp),
        .fixed_pulse (fixed_pulse),
        .count_en    (count_en)
    );

    timer_counter #(.CW(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .count_en  (count_en),
        .load      (wr_count),
        .top_val   (top_q),
        .start_val (start_q),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    always_comb begin
        rd = '0;
        unique case (ofs)
            OFS_CTRL:  rd = ctrl_to_word(ctrl);
            OFS_COUNT: rd[CNT_W-1:0] = cnt;
            OFS_TOP:   rd[CNT_W-1:0] = top_q;
            OFS_START: rd[CNT_W-1:0] = start_q;
            default:   rd = '0;
        endcase
    end

    assign irq = ctrl.flag & ctrl.irq_en;

    assert_flag_on_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ctrl.flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flag && !clear_req) |=> ctrl.flag);

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src == SRC_OFF && !wr_count) |=> (cnt == $past(cnt)));

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.flag && ctrl.irq_en));

endmodule

// File: tb/reload_alarm_timer_bench.sv
`timescale 1ns/1ps
module reload_alarm_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        irq;

    logic        be_we = 1'b0;
    logic [7:0]  be_addr = 8'h00;
    logic [31:0] be_wdata = '0;
    logic [31:0] be_rdata;
    logic        be_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    reload_alarm_timer u_reload_alarm_timer (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .tick_in(tick), .bus_rdata(rdata), .irq(irq)
    );

    reload_alarm_timer #(.BIG_ENDIAN(1'b1)) u_be (
        .clk(clk), .rst(rst), .bus_we(be_we), .bus_addr(be_addr),
        .bus_wdata(be_wdata), .tick_in(1'b0), .bus_rdata(be_rdata), .irq(be_irq)
    );

    function automatic logic [31:0] ctl(int src, int e, int ie, int fl);
        return 32'((fl << 7) | (ie << 6) | (src << 3) | e);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called just after a falling edge; the write is taken on the next rising edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic be_wr(logic [7:0] a, logic [31:0] d);
        be_we = 1'b1; be_addr = a; be_wdata = d;
        @(negedge clk);
        be_we = 1'b0;
    endtask

    task automatic setup(int s, int m, int src, int e);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'(m));
        wr(8'h4C, 32'(s));
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h00, ctl(src, e, 0, 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int starts[3] = '{0, 2, 5};
        int tops[3]   = '{3, 6, 5};
        int waits[5]  = '{1, 3, 7, 13, 24};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h04, v); check("R1 count", v, 32'h0);
        rd(8'h08, v); check("R1 top", v, 32'h0);
        rd(8'h4C, v); check("R1 start", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 field layout and unmapped offset
        wr(8'h00, 32'hFFFF_FF7F);
        rd(8'h00, v); check("R2 ctrl readback", v, 32'h0000_005F);
        rd(8'h10, v); check("R2 unmapped", v, 32'h0);
        wr(8'h00, 32'h0);

        // R10 width trimming
        wr(8'h08, 32'h0001_2345);
        rd(8'h08, v); check("R10 top trimmed", v, 32'h0000_2345);
        wr(8'h4C, 32'hABCD_0011);
        rd(8'h4C, v); check("R10 start trimmed", v, 32'h0000_0011);

        // R5 R6 R7: sweep divider, start/top pairs and elapsed cycles on bus source
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 5; k++) begin
                    int counts, period, expv, expf;
                    setup(starts[p], tops[p], 1, e);
                    repeat (waits[k]) @(negedge clk);
                    counts = waits[k] >> e;
                    period = tops[p] - starts[p] + 1;
                    expv   = starts[p] + (counts % period);
                    expf   = (counts >= period) ? 1 : 0;
                    rd(8'h04, v); check("R5 R6 count value", v, 32'(expv));
                    rd(8'h00, v); check("R7 wrap flag", {31'b0, v[7]}, 32'(expf));
                end
            end
        end

        // R4: fixed tick source
        for (int e = 0; e < 4; e++) begin
            setup(0, 16'hFFFF, 2, e);
            for (int t = 0; t < 10; t++) begin
                tick = 1'b1; repeat (3) @(negedge clk);
                tick = 1'b0; repeat (3) @(negedge clk);
            end
            repeat (5) @(negedge clk);
            rd(8'h04, v); check("R4 tick count", v, 32'(10 >> e));
        end

        // R3: stopped sources hold the count
        setup(4, 9, 3, 0);
        repeat (10) @(negedge clk);
        rd(8'h04, v); check("R3 reserved source holds", v, 32'd4);
        setup(4, 9, 1, 0);
        repeat (3) @(negedge clk);
        wr(8'h00, ctl(0, 0, 0, 0));
        rd(8'h04, v);
        repeat (8) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(8'h04, v2); check("R3 off source holds", v2, v);
        end
        check("R3 bus source advanced", v, 32'd8);

        // R8: clear coinciding with reload keeps flag; then clear; write 1 no effect
        setup(0, 3, 1, 0);                 // enable on edge E0
        repeat (3) @(negedge clk);         // past E3, counter at 3
        wr(8'h00, ctl(1, 0, 0, 0));        // clearing write on reload edge E4
        rd(8'h00, v); check("R8 reload beats clear", {31'b0, v[7]}, 32'h1);
        rd(8'h04, v); check("R6 reloaded to start", v, 32'h0);
        wr(8'h00, ctl(1, 0, 0, 1));        // E5: write 1, no reload
        rd(8'h00, v); check("R8 write one keeps flag", {31'b0, v[7]}, 32'h1);
        wr(8'h00, ctl(1, 0, 0, 0));        // E6: clear
        rd(8'h00, v); check("R8 clear by zero", {31'b0, v[7]}, 32'h0);
        wr(8'h00, ctl(0, 0, 0, 1));        // E7: stop, write 1 with flag clear
        rd(8'h00, v); check("R8 write one cannot set", {31'b0, v[7]}, 32'h0);

        // R9: counter write loads start value mid-run
        setup(3, 200, 1, 0);
        repeat (20) @(negedge clk);
        rd(8'h04, v); check("R9 running before load", v, 32'd23);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, v); check("R9 load start value", v, 32'd3);

        // R11: irq gating
        setup(0, 0, 1, 0);
        repeat (2) @(negedge clk);
        check("R11 irq off without enable", {31'b0, irq}, 32'h0);
        wr(8'h00, ctl(0, 0, 1, 1));
        check("R11 irq on with flag and enable", {31'b0, irq}, 32'h1);
        wr(8'h00, ctl(0, 0, 1, 0));
        check("R11 irq off after clear", {31'b0, irq}, 32'h0);

        // R12: big-endian instance
        be_wr(8'h08, 32'h3412_0000);
        be_addr = 8'h08; #0.5;
        check("R12 swapped readback", be_rdata, 32'h3412_0000);
        be_wr(8'h00, 32'h4800_0000);       // source 1, enable, top 0x1234
        repeat (4700) @(negedge clk);
        check("R12 irq via swapped control", {31'b0, be_irq}, 32'h1);
        be_addr = 8'h00; #0.5;
        check("R12 control reads swapped", be_rdata, 32'hC800_0000);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule